// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block is the software-visible control store for a PHY sequencer. It holds seven 16-bit control words and one read-only status word on a simple synchronous bus with a valid strobe, a write flag, a byte address and 32-bit write data. Every write carries a bit-enable mask in its upper 16 bits. Stored bit x takes the value of write-data bit x only when write-data bit x+16 is set. Software can therefore flip single control bits without first reading the register back.

The bank decodes fixed control fields out of two of its words and drives them straight to the PHY sequencer. The power-up, DLL enable and drive-strength controls come from one word. The DLL frequency band and the output tap delay controls come from another. The sequencer returns a calibration-done flag and a DLL-ready flag, and software polls them through the status word.

Reads are registered. A read presented in one cycle returns its data, with a one-cycle valid pulse, in the next cycle.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a control word, stored bit x (0..15) takes write-data bit x when write-data bit x+16 is 1, and keeps its old value when bit x+16 is 0.
- R2: Control word n (n = 0..6) sits at byte offset 4·n (0x00 to 0x18), and the status word sits at byte offset 0x20.
- R3: Control word 6 drives the PHY: bit 0 is the power-up control (`phyPowerOn`), bit 1 is the DLL enable (`dllEnable`), and bits 6:4 are the drive-strength select (`driveSel`).
- R4: Control word 0 drives the PHY: bits 13:12 are the DLL frequency band (`dllFreqSel`), bit 11 is the output tap delay enable (`txTapEnable`), and bits 10:7 are the output tap delay select (`txTapSel`).
- R5: A status read returns `calDone` in bit 6 and `dllReady` in bit 5, sampled at the read cycle, with all other bits zero.
- R6: Bits 31:16 of every read return zero.
- R7: A write to the status offset changes no control word.
- R8: After reset, every control word and every decoded control output is zero.
- R9: A read from an unmapped offset returns zero, and a write to one changes nothing. Offsets whose low two bits are not 00 count as unmapped, as do 0x1C and everything above 0x20.
- R10: A read accepted in cycle t raises `busRvalid` for exactly cycle t+1, with `busRdata` valid in that cycle. A write never raises `busRvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus request valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte address |
| busWdata | input | DATA_W (32) | Write data; upper half is the bit-enable mask |
| busRdata | output | DATA_W (32) | Registered read data |
| busRvalid | output | 1 | Read data valid, one cycle after the read |
| calDone | input | 1 | Calibration-done flag from the sequencer |
| dllReady | input | 1 | DLL-ready flag from the sequencer |
| phyPowerOn | output | 1 | Power-up control (word 6 bit 0) |
| dllEnable | output | 1 | DLL enable (word 6 bit 1) |
| driveSel | output | 3 | Drive-strength select (word 6 bits 6:4) |
| dllFreqSel | output | 2 | DLL frequency band (word 0 bits 13:12) |
| txTapEnable | output | 1 | Output tap delay enable (word 0 bit 11) |
| txTapSel | output | 4 | Output tap delay select (word 0 bits 10:7) |

## Verification
The bench builds the bank with its default parameters: an 8-bit address, a 32-bit data word and seven control words. With an 8-bit address, the bench can reach every misaligned offset, the gap at 0x1C and the offsets far above the status word. It can therefore show that no write outside the seven words and the status slot reaches storage. Seven words also put both field-carrying words, 0 and 6, at the two ends of the control range. The first and last decode slots are then exercised through real outputs, not just through read-back.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int NUM_CTRL = 7;
  localparam int SEL_W    = $clog2(NUM_CTRL);

  // field positions decoded by the PHY sequencer
  localparam int PWR_WORD   = 6;
  localparam int PWR_BIT    = 0;
  localparam int DLLEN_BIT  = 1;
  localparam int DRV_LSB    = 4;
  localparam int TAP_WORD   = 0;
  localparam int FREQ_LSB   = 12;
  localparam int TAPEN_BIT  = 11;
  localparam int TAPSEL_LSB = 7;
  localparam int CAL_BIT    = 6;
  localparam int RDY_BIT    = 5;

  typedef struct packed {
    logic [NUM_CTRL-1:0] wrEn;
    logic                rdEn;
    logic                rdCtrl;
    logic                rdStatus;
    logic [SEL_W-1:0]    rdSel;
  } strobe_t;
endpackage

// File: rtl/phy_ctl_decode.sv
module phy_ctl_decode
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             ctrlHit;
  logic             statusHit;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign aligned   = (busAddr[1:0] == 2'b00);
  assign ctrlHit   = aligned && (int'(wordIdx) < NUM_CTRL);
  assign statusHit = aligned && (int'(busAddr) == STATUS_ADDR);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_wr
    assign strb.wrEn[i] = busValid && busWrite && ctrlHit && (int'(wordIdx) == i);
  end

  assign strb.rdEn     = busValid && !busWrite;
  assign strb.rdCtrl   = strb.rdEn && ctrlHit;
  assign strb.rdStatus = strb.rdEn && statusHit;
  assign strb.rdSel    = wordIdx[SEL_W-1:0];

  p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.wrEn));
  p_rd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.rdCtrl && strb.rdStatus));
  p_no_wr_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdEn |-> (strb.wrEn == '0));
endmodule

// File: rtl/phy_ctl_store.sv
module phy_ctl_store
  import phy_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              calDone,
  input  logic              dllReady,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic [HALF_W-1:0] ctrlQ [NUM_CTRL]
);
  logic [HALF_W-1:0] wrMask;
  logic [HALF_W-1:0] wrBits;
  logic [HALF_W-1:0] statusWord;
  logic [HALF_W-1:0] rdWord;

  assign wrMask = busWdata[DATA_W-1:HALF_W];
  assign wrBits = busWdata[HALF_W-1:0];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrlQ[i] <= '0;
      end else if (strb.wrEn[i]) begin
        ctrlQ[i] <= (ctrlQ[i] & ~wrMask) | (wrBits & wrMask);
      end
    end

    p_masked_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      strb.wrEn[i] |=> (((ctrlQ[i] ^ $past(ctrlQ[i])) & ~$past(wrMask)) == '0));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.wrEn[i] |=> $stable(ctrlQ[i]));
  end

  always_comb begin
    statusWord          = '0;
    statusWord[CAL_BIT] = calDone;
    statusWord[RDY_BIT] = dllReady;
  end

  always_comb begin
    rdWord = '0;
    if (strb.rdCtrl) begin
      rdWord = ctrlQ[strb.rdSel];
    end else if (strb.rdStatus) begin
      rdWord = statusWord;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strb.rdEn;
      if (strb.rdEn) begin
        busRdata <= {{HALF_W{1'b0}}, rdWord};
      end
    end
  end

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busRvalid |-> (busRdata[DATA_W-1:HALF_W] == '0));
  p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdEn |=> busRvalid);
  p_status_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdStatus |=> (busRdata[CAL_BIT] == $past(calDone)));
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic              calDone,
  input  logic              dllReady,
  output logic              phyPowerOn,
  output logic              dllEnable,
  output logic [2:0]        driveSel,
  output logic [1:0]        dllFreqSel,
  output logic              txTapEnable,
  output logic [3:0]        txTapSel
);
  strobe_t           strb;
  logic [HALF_W-1:0] ctrlQ [NUM_CTRL];

  phy_ctl_decode #(.ADDR_W(ADDR_W), .STATUS_ADDR(32)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  phy_ctl_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .busWdata  (busWdata),
    .calDone   (calDone),
    .dllReady  (dllReady),
    .busRdata  (busRdata),
    .busRvalid (busRvalid),
    .ctrlQ     (ctrlQ)
  );

  assign phyPowerOn  = ctrlQ[PWR_WORD][PWR_BIT];
  assign dllEnable   = ctrlQ[PWR_WORD][DLLEN_BIT];
  assign driveSel    = ctrlQ[PWR_WORD][DRV_LSB +: 3];
  assign dllFreqSel  = ctrlQ[TAP_WORD][FREQ_LSB +: 2];
  assign txTapEnable = ctrlQ[TAP_WORD][TAPEN_BIT];
  assign txTapSel    = ctrlQ[TAP_WORD][TAPSEL_LSB +: 4];

  p_write_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite) |=> !busRvalid);
  p_outputs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busValid && busWrite) |=> ($stable(phyPowerOn) && $stable(driveSel) && $stable(txTapSel)));
endmodule

// File: tb/phy_ctl_regbank_tb_top.sv
module phy_ctl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        calDone = 1'b0;
  logic        dllReady = 1'b0;
  logic        phyPowerOn, dllEnable, txTapEnable;
  logic [2:0]  driveSel;
  logic [1:0]  dllFreqSel;
  logic [3:0]  txTapSel;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [7];

  always #2 clk = ~clk;

  phy_ctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .calDone(calDone), .dllReady(dllReady),
    .phyPowerOn(phyPowerOn), .dllEnable(dllEnable), .driveSel(driveSel),
    .dllFreqSel(dllFreqSel), .txTapEnable(txTapEnable), .txTapSel(txTapSel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    if (addr[1:0] == 2'b00 && addr < 8'h1c) begin
      model[addr[4:2]] = (model[addr[4:2]] & ~data[31:16]) | (data[15:0] & data[31:16]);
    end
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] data, output logic vld);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = addr;
    @(negedge clk);
    busValid = 1'b0;
    data = busRdata; vld = busRvalid;
  endtask

  task automatic check_all_words(input string req);
    logic [31:0] d; logic v;
    for (int n = 0; n < 7; n++) begin
      rd(8'(4 * n), d, v);
      check(v && d == {16'h0, model[n]}, req, d, {16'h0, model[n]});
    end
  endtask

  task automatic t_reset;
    check({phyPowerOn, dllEnable, driveSel, dllFreqSel, txTapEnable, txTapSel} == '0,
          "R8 outputs", {18'h0, phyPowerOn, dllEnable, driveSel, dllFreqSel, txTapEnable, txTapSel}, 0);
    check(!busRvalid, "R10 idle rvalid", 32'(busRvalid), 0);
    check_all_words("R8 words");
  endtask

  task automatic t_offsets;
    for (int n = 0; n < 7; n++) wr(8'(4 * n), {16'hFFFF, 16'(16'h1111 * (n + 1))});
    check_all_words("R2 offsets");
  endtask

  task automatic t_masked;
    logic [31:0] d; logic v;
    wr(8'h08, 32'hFFFF_A5A5);
    wr(8'h08, 32'h00F0_0F0F);
    rd(8'h08, d, v);
    check(d == 32'h0000_A505, "R1 masked", d, 32'h0000_A505);
    wr(8'h08, 32'h0000_FFFF);
    rd(8'h08, d, v);
    check(d == 32'h0000_A505, "R1 zero mask", d, 32'h0000_A505);
    wr(8'h08, 32'h8001_0000);
    rd(8'h08, d, v);
    check(d == 32'h0000_2504, "R1 single bits", d, 32'h0000_2504);
  endtask

  task automatic t_fields6;
    wr(8'h18, 32'hFFFF_0000);
    wr(8'h18, 32'h0073_0051);
    check(phyPowerOn && !dllEnable && driveSel == 3'd5, "R3 pwr/drv",
          {29'h0, driveSel}, 32'd5);
    wr(8'h18, 32'h0002_0002);
    check(phyPowerOn && dllEnable && driveSel == 3'd5, "R3 dll enable",
          {30'h0, dllEnable, phyPowerOn}, 32'd3);
    wr(8'h18, 32'h0001_0000);
    check(!phyPowerOn && dllEnable, "R3 power off", {30'h0, dllEnable, phyPowerOn}, 32'd2);
  endtask

  task automatic t_fields0;
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h00, 32'h3F80_2C80);
    check(dllFreqSel == 2'd2 && txTapEnable && txTapSel == 4'd9, "R4 fields",
          {25'h0, dllFreqSel, txTapEnable, txTapSel}, {25'h0, 2'd2, 1'b1, 4'd9});
    wr(8'h00, 32'h3000_3000);
    check(dllFreqSel == 2'd3 && txTapSel == 4'd9, "R4 band only",
          {25'h0, dllFreqSel, txTapEnable, txTapSel}, {25'h0, 2'd3, 1'b1, 4'd9});
  endtask

  task automatic t_status;
    logic [31:0] d; logic v;
    calDone = 1'b1; dllReady = 1'b0;
    rd(8'h20, d, v);
    check(v && d == 32'h40, "R5 cal", d, 32'h40);
    calDone = 1'b0; dllReady = 1'b1;
    rd(8'h20, d, v);
    check(d == 32'h20, "R5 ready", d, 32'h20);
    calDone = 1'b1;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d, v);
    check(d == 32'h60, "R5 both", d, 32'h60);
    check_all_words("R7 status write");
  endtask

  task automatic t_upper;
    logic [31:0] d; logic v;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d, v);
    check(d == 32'h0000_FFFF, "R6 upper zero", d, 32'h0000_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic v;
    wr(8'h1c, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_0000);
    wr(8'h02, 32'hFFFF_0000);
    wr(8'hFC, 32'hFFFF_0000);
    check_all_words("R9 unmapped write");
    rd(8'h1c, d, v);
    check(v && d == 0, "R9 read 0x1c", d, 0);
    rd(8'h05, d, v);
    check(d == 0, "R9 read misaligned", d, 0);
    rd(8'h80, d, v);
    check(d == 0, "R9 read high", d, 0);
  endtask

  task automatic t_rvalid;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 8'h04;
    @(negedge clk);
    busValid = 1'b0;
    check(busRvalid, "R10 pulse", 32'(busRvalid), 1);
    @(negedge clk);
    check(!busRvalid, "R10 single cycle", 32'(busRvalid), 0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 8'h04; busWdata = 32'h0;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check(!busRvalid, "R10 write no rvalid", 32'(busRvalid), 0);
  endtask

  initial begin
    #(4 * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 7; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offsets();
    t_masked();
    t_fields6();
    t_fields0();
    t_status();
    t_upper();
    t_unmapped();
    t_rvalid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule